// File: doc/BRIEF.md
# Grouped Lookahead Adder-Subtractor

This block adds or subtracts two two's-complement operands of a configurable width. The default width is 16 bits. It reports the result, the carry out of the most significant bit and a signed overflow flag. Each bit forms a generate term (both operand bits set) and a propagate term (the operand bits differ). Bits are collected into 4-bit groups. Inside each group, all four carries are written out as flat sum-of-products expressions of the group's generate and propagate terms and the carry entering the group. Each group also exports a group generate and a group propagate. A second lookahead stage, built from the same 4-bit unit, combines these group terms to give the carry entering every group.

Subtraction adds the two's complement of the second operand. The second operand passes through an XOR stage controlled by the subtract input, and the carry-in is forced to one to supply the +1. The external carry-in is ignored while subtracting. The arithmetic core is combinational. The result, carry and overflow are captured in output registers, so a result appears one clock edge after its operands. The width must be a multiple of 4.

Top module: `addsub_cla`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs are cleared on that edge: `sum` = 0, `cout` = 0 and `ovf` = 0.
- R2: When `sub` is 0, `sum` equals (`op_a` + `op_b` + `cin`) modulo 2^W one rising edge after the operands are applied.
- R3: When `sub` is 0, `cout` equals bit W of the (W+1)-bit sum `op_a` + `op_b` + `cin`.
- R4: When `sub` is 1, `sum` equals (`op_a` − `op_b`) modulo 2^W, computed as `op_a` + ~`op_b` + 1, one rising edge after the operands are applied.
- R5: When `sub` is 1, `cin` has no effect on `sum`, `cout` or `ovf`. `cout` is 1 exactly when `op_a` ≥ `op_b` as unsigned values, meaning no borrow.
- R6: `ovf` is 1 exactly when the signed result does not fit in W bits. This equals the XOR of the carry into the MSB and the carry out of the MSB. For addition, it means the operands share a sign and the result's sign differs. For subtraction, it means the operands' signs differ and the result's sign differs from `op_a`'s.
- R7: A carry generated in the lowest bit reaches `cout` through every group. For example, `op_a` = all ones, `op_b` = 0, `cin` = 1 gives `sum` = 0 and `cout` = 1, and the carry leaving each group equals the carry the second stage delivers into the next group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| op_a | input | W | First operand (minuend when subtracting) |
| op_b | input | W | Second operand (subtrahend when subtracting) |
| sub | input | 1 | 1 selects op_a − op_b, 0 selects op_a + op_b + cin |
| cin | input | 1 | Carry-in for addition, ignored when subtracting |
| sum | output | W | Registered result |
| cout | output | 1 | Registered carry out of the MSB (1 = no borrow when subtracting) |
| ovf | output | 1 | Registered signed overflow flag |

## Verification
The operands 0, all ones, the most negative value and the most positive value are applied in both modes. These cases separate a correct carry and overflow from formulas that only work away from the sign boundary. An all-ones operand with a carry-in, and a subtraction of equal values, drive a carry through every group. These two patterns expose a broken group propagate or a broken second-stage link. Subtractions repeated with both carry-in values show that the carry-in is ignored in that mode. A pseudo-random operand stream, compared against plain integer arithmetic, covers mixed generate and kill patterns in every group.

// File: rtl/addsub_cla_pkg.sv
package addsub_cla_pkg;
  localparam int GRP_BITS = 4;

  function automatic int ceil_div(input int n, input int d);
    return (n + d - 1) / d;
  endfunction
endpackage

// File: rtl/addsub_lcu4.sv
// Four-wide lookahead unit: flattened carries plus block generate/propagate.
module addsub_lcu4 (
  input  logic [3:0] g,
  input  logic [3:0] p,
  input  logic       cin,
  output logic [3:0] c,
  output logic       gg,
  output logic       pg
);
  always_comb begin
    c[0] = g[0] | (p[0] & cin);
    c[1] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
    c[2] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
         | (p[2] & p[1] & p[0] & cin);
    c[3] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
         | (p[3] & p[2] & p[1] & g[0])
         | (p[3] & p[2] & p[1] & p[0] & cin);
    gg   = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
         | (p[3] & p[2] & p[1] & g[0]);
    pg   = &p;
  end
endmodule

// File: rtl/addsub_cla_group.sv
// One 4-bit slice: bit generate/propagate, local lookahead, sum bits.
module addsub_cla_group
  import addsub_cla_pkg::*;
(
  input  logic [GRP_BITS-1:0] a,
  input  logic [GRP_BITS-1:0] b,
  input  logic                cin,
  output logic [GRP_BITS-1:0] s,
  output logic [GRP_BITS-1:0] c,
  output logic                gg,
  output logic                pg
);
  logic [GRP_BITS-1:0] bit_g;
  logic [GRP_BITS-1:0] bit_p;
  logic [GRP_BITS-1:0] c_in_bit;

  assign bit_g = a & b;
  assign bit_p = a ^ b;

  addsub_lcu4 u_lcu (
    .g   (bit_g),
    .p   (bit_p),
    .cin (cin),
    .c   (c),
    .gg  (gg),
    .pg  (pg)
  );

  assign c_in_bit = {c[GRP_BITS-2:0], cin};
  assign s        = bit_p ^ c_in_bit;
endmodule

// File: rtl/addsub_cla_tree.sv
// Second lookahead level: combines group G/P into the carry entering each group.
module addsub_cla_tree
  import addsub_cla_pkg::*;
#(
  parameter int NGRP = 4
) (
  input  logic [NGRP-1:0] grp_g,
  input  logic [NGRP-1:0] grp_p,
  input  logic            cin,
  output logic [NGRP-1:0] grp_cin,
  output logic            cout_chain,
  output logic            cout_flat
);
  localparam int NSUP = ceil_div(NGRP, GRP_BITS);
  localparam int NPAD = NSUP * GRP_BITS;

  logic [NPAD-1:0] pad_g;
  logic [NPAD-1:0] pad_p;
  logic [NPAD-1:0] grp_cout;
  logic [NSUP-1:0] sup_g;
  logic [NSUP-1:0] sup_p;
  logic [NSUP:0]   sup_cin;

  // Padding slots propagate so the top slot carries the real top carry.
  for (genvar j = 0; j < NPAD; j++) begin : g_pad
    if (j < NGRP) begin : g_real
      assign pad_g[j] = grp_g[j];
      assign pad_p[j] = grp_p[j];
    end else begin : g_fill
      assign pad_g[j] = 1'b0;
      assign pad_p[j] = 1'b1;
    end
  end

  assign sup_cin[0] = cin;

  for (genvar k = 0; k < NSUP; k++) begin : g_sup
    addsub_lcu4 u_lcu (
      .g   (pad_g[k*GRP_BITS +: GRP_BITS]),
      .p   (pad_p[k*GRP_BITS +: GRP_BITS]),
      .cin (sup_cin[k]),
      .c   (grp_cout[k*GRP_BITS +: GRP_BITS]),
      .gg  (sup_g[k]),
      .pg  (sup_p[k])
    );
    assign sup_cin[k+1] = sup_g[k] | (sup_p[k] & sup_cin[k]);
  end

  assign grp_cin[0] = cin;
  for (genvar j = 1; j < NGRP; j++) begin : g_link
    assign grp_cin[j] = grp_cout[j-1];
  end

  assign cout_chain = sup_cin[NSUP];
  assign cout_flat  = grp_cout[NPAD-1];
endmodule

// File: rtl/addsub_cla.sv
module addsub_cla
  import addsub_cla_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int NGRP = W / GRP_BITS;

  if (W % GRP_BITS != 0 || W < GRP_BITS) begin : g_bad_width
    $error("addsub_cla: W must be a positive multiple of 4");
  end

  logic [W-1:0]    b_eff;
  logic            cin_eff;
  logic [W-1:0]    sum_d;
  logic [W-1:0]    bit_cout;
  logic [NGRP-1:0] grp_g;
  logic [NGRP-1:0] grp_p;
  logic [NGRP-1:0] grp_cin;
  logic            cout_chain;
  logic            cout_flat;
  logic            ovf_d;

  // Subtract: invert B, supply the +1 through the carry-in.
  assign b_eff   = op_b ^ {W{sub}};
  assign cin_eff = sub | cin;

  for (genvar i = 0; i < NGRP; i++) begin : g_grp
    addsub_cla_group u_grp (
      .a   (op_a[i*GRP_BITS +: GRP_BITS]),
      .b   (b_eff[i*GRP_BITS +: GRP_BITS]),
      .cin (grp_cin[i]),
      .s   (sum_d[i*GRP_BITS +: GRP_BITS]),
      .c   (bit_cout[i*GRP_BITS +: GRP_BITS]),
      .gg  (grp_g[i]),
      .pg  (grp_p[i])
    );
  end

  addsub_cla_tree #(
    .NGRP (NGRP)
  ) u_tree (
    .grp_g      (grp_g),
    .grp_p      (grp_p),
    .cin        (cin_eff),
    .grp_cin    (grp_cin),
    .cout_chain (cout_chain),
    .cout_flat  (cout_flat)
  );

  assign ovf_d = bit_cout[W-1] ^ bit_cout[W-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      sum  <= sum_d;
      cout <= cout_chain;
      ovf  <= ovf_d;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (sum == '0 && !cout && !ovf));

  // R2
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sub)) |->
      ({cout, sum} == $past({1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, cin})));

  // R4
  sub_result_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sub)) |->
      ({cout, sum} == $past({1'b0, op_a} + {1'b0, ~op_b} + {{W{1'b0}}, 1'b1})));

  // R6
  ovf_sign_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      (ovf == (($past(op_a[W-1]) == $past(op_b[W-1] ^ sub))
               && (sum[W-1] != $past(op_a[W-1])))));

  // R3
  cout_path_chk: assert property (@(posedge clk) disable iff (rst)
    (cout_flat == cout_chain) && (bit_cout[W-1] == cout_chain));

  for (genvar i = 0; i + 1 < NGRP; i++) begin : g_link_chk
    // R7
    carry_link_chk: assert property (@(posedge clk) disable iff (rst)
      bit_cout[i*GRP_BITS + GRP_BITS-1] == grp_cin[i+1]);
  end
endmodule

// File: tb/test_addsub_cla.sv
module test_addsub_cla;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         sub = 1'b0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;
  logic         ovf;

  int checks = 0;
  int fails  = 0;
  logic [31:0] seed = 32'h1357_9bdf;

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] MNEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MPOS = {1'b0, {(W-1){1'b1}}};

  addsub_cla #(.W(W)) i_addsub_cla (
    .clk  (clk),
    .rst  (rst),
    .op_a (op_a),
    .op_b (op_b),
    .sub  (sub),
    .cin  (cin),
    .sum  (sum),
    .cout (cout),
    .ovf  (ovf)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    report();
    $finish;
  end

  task automatic check(input string tag, input logic [W+1:0] act,
                       input logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {cout,ovf,sum}=%h expected %h", tag, act, exp);
    end
  endtask

  // Drives one operation at a falling edge, checks at the next falling edge.
  task automatic run_op(input string tag, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic s, input logic c);
    logic [W-1:0] bb;
    logic [W:0]   full;
    logic         ci;
    logic         ov;
    @(negedge clk);
    op_a = a; op_b = b; sub = s; cin = c;
    bb   = s ? ~b : b;
    ci   = s ? 1'b1 : c;
    full = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, ci};
    ov   = (a[W-1] == bb[W-1]) && (full[W-1] != a[W-1]);
    @(negedge clk);
    check(tag, {cout, ovf, sum}, {full[W], ov, full[W-1:0]});
  endtask

  task automatic t_reset;
    @(negedge clk);
    op_a = ONES; op_b = ONES; sub = 1'b0; cin = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 reset", {cout, ovf, sum}, '0);
    rst = 1'b0;
  endtask

  task automatic t_add_corners;
    run_op("R2 add 0+0", ZERO, ZERO, 1'b0, 1'b0);
    run_op("R2 add 0+0+cin", ZERO, ZERO, 1'b0, 1'b1);
    run_op("R3 add ones+ones", ONES, ONES, 1'b0, 1'b0);
    run_op("R3 add ones+1", ONES, 16'h0001, 1'b0, 1'b0);
    run_op("R2 add mixed", 16'h1234, 16'h4321, 1'b0, 1'b1);
    run_op("R3 add mneg+mneg", MNEG, MNEG, 1'b0, 1'b0);
  endtask

  task automatic t_sub_corners;
    run_op("R4 sub 0-0", ZERO, ZERO, 1'b1, 1'b0);
    run_op("R4 sub 0-1", ZERO, 16'h0001, 1'b1, 1'b0);
    run_op("R5 sub equal", 16'hA5A5, 16'hA5A5, 1'b1, 1'b0);
    run_op("R5 sub a<b borrow", 16'h0010, 16'h0100, 1'b1, 1'b0);
    run_op("R4 sub ones-mneg", ONES, MNEG, 1'b1, 1'b0);
  endtask

  task automatic t_cin_ignored;
    run_op("R5 sub cin=0", 16'h3C00, 16'h00FF, 1'b1, 1'b0);
    run_op("R5 sub cin=1", 16'h3C00, 16'h00FF, 1'b1, 1'b1);
    run_op("R5 sub 0-0 cin=1", ZERO, ZERO, 1'b1, 1'b1);
  endtask

  task automatic t_overflow;
    run_op("R6 add mpos+1", MPOS, 16'h0001, 1'b0, 1'b0);
    run_op("R6 add mneg+ones", MNEG, ONES, 1'b0, 1'b0);
    run_op("R6 add mpos+0+cin", MPOS, ZERO, 1'b0, 1'b1);
    run_op("R6 sub 0-mneg", ZERO, MNEG, 1'b1, 1'b0);
    run_op("R6 sub mneg-1", MNEG, 16'h0001, 1'b1, 1'b0);
    run_op("R6 sub mpos-ones", MPOS, ONES, 1'b1, 1'b0);
    run_op("R6 sub mneg-mneg", MNEG, MNEG, 1'b1, 1'b0);
  endtask

  task automatic t_propagate;
    run_op("R7 ones+0+cin", ONES, ZERO, 1'b0, 1'b1);
    run_op("R7 alt pattern", 16'hAAAA, 16'h5555, 1'b0, 1'b1);
    run_op("R7 group edge", 16'h0FFF, 16'h0001, 1'b0, 1'b0);
    run_op("R7 sub ones-ones", ONES, ONES, 1'b1, 1'b1);
  endtask

  task automatic t_random;
    for (int n = 0; n < 400; n++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      run_op(seed[0] ? "R4 random sub" : "R2 random add",
             seed[31:16], seed[23:8], seed[0], seed[1]);
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset at start", {cout, ovf, sum}, '0);
    rst = 1'b0;
    t_add_corners();
    t_sub_corners();
    t_cin_ignored();
    t_overflow();
    t_propagate();
    t_reset();
    t_random();
    report();
    $finish;
  end
endmodule